// File: doc/BRIEF.md
# Counter Clock and Gate Source Selector

This block sits beside a group of three-channel counter chips and decides, for every counter channel, where its clock and its gate come from. Each channel keeps a 3-bit clock-source code and a 3-bit gate-source code. Software sets these codes through a small register port, one write per code, and can read them back. The counters are not part of the block. Their outputs arrive as inputs, and the selected clock and gate leave as outputs.

Clock sources are the channel's own pin, the chip's shared external clock, a neighbouring channel's output, or one of five internal rates. The internal rates come from a chain of divide-by-ten prescalers driven by a base tick. Gate sources are a fixed high or low level, the channel's own pin, or the inverted output of a neighbouring channel. The chips are linked in a ring. Whenever a channel's dedicated clock or gate pin is not the selected source, the block turns that pin into an output and drives the selected signal onto it.

Top module: `ctr_src_select`

## Requirements
- R1: After reset every channel holds clock code 0 and gate code 0. As a result every clock pin is an input (`clk_pin_oe_o` low) and every gate pin is an output driven high (`gat_pin_oe_o` and `cnt_gate_o` high).
- R2: A write with `wr_en_i` high stores `wr_code_i` for the channel at flat index chip*3+channel. `wr_gate_i` low selects the clock code and high selects the gate code. `rd_code_o` returns the addressed code without delay.
- R3: A write whose channel index is 3, or whose chip index is not below NUM_CHIPS, changes no stored code. Reading such an address returns 0.
- R4: Clock code 0 routes the channel's own `clk_pin_i` bit. Clock code 7 routes the chip's `ext_clk_i` bit, which all three channels of that chip share.
- R5: Clock codes 1 to 5 route the internal rates. Code 1 is the base tick itself. Code k for k in 2 to 5 is a one-cycle strobe that fires on every 10^(k-1)-th base tick, counted from reset.
- R6: Clock code 6 routes the output of channel n-1 on the same chip for n>0. For channel 0 it routes the output of channel 2 on the preceding chip, and chip 0 is preceded by the highest chip.
- R7: Gate code 0 gives a high gate, code 1 a low gate, and code 2 the channel's own `gat_pin_i` bit.
- R8: Gate code 3 gives the inverted output of channel 0 on the same chip for channel 2. For channel n<2 it gives the inverted output of channel n+1 on the preceding chip, using the same ring as R6.
- R9: Gate codes 4 to 7 force the gate low.
- R10: `clk_pin_oe_o` is high exactly when the clock code is not 0, and `gat_pin_oe_o` is high exactly when the gate code is not 2. An enabled pin carries the selected clock or gate. A disabled pin's input reaches the counter unchanged.
- R11: Routing from pins, counter outputs and strobes to `cnt_clk_o` and `cnt_gate_o` is combinational. A written code takes effect from the clock edge that captures the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_base_i | input | 1 | One-cycle base-rate tick (fastest internal clock) |
| wr_en_i | input | 1 | Code write strobe |
| wr_gate_i | input | 1 | 0 writes the clock code, 1 writes the gate code |
| wr_chip_i | input | idx_w(NUM_CHIPS) | Chip index of the write |
| wr_chan_i | input | 2 | Channel index of the write (0 to 2) |
| wr_code_i | input | 3 | Code to store |
| rd_gate_i | input | 1 | 0 reads the clock code, 1 reads the gate code |
| rd_chip_i | input | idx_w(NUM_CHIPS) | Chip index of the read |
| rd_chan_i | input | 2 | Channel index of the read |
| rd_code_o | output | 3 | Addressed code |
| ext_clk_i | input | NUM_CHIPS | Shared external clock, one per chip |
| clk_pin_i | input | 3*NUM_CHIPS | Per-channel clock pin input |
| gat_pin_i | input | 3*NUM_CHIPS | Per-channel gate pin input |
| cnt_out_i | input | 3*NUM_CHIPS | Counter channel outputs |
| cnt_clk_o | output | 3*NUM_CHIPS | Selected clock to each counter channel |
| cnt_gate_o | output | 3*NUM_CHIPS | Selected gate to each counter channel |
| clk_pin_o | output | 3*NUM_CHIPS | Value driven on each clock pin |
| clk_pin_oe_o | output | 3*NUM_CHIPS | Clock pin output enable |
| gat_pin_o | output | 3*NUM_CHIPS | Value driven on each gate pin |
| gat_pin_oe_o | output | 3*NUM_CHIPS | Gate pin output enable |

## Verification
Routing is combinational, so the bench changes pin, counter-output and tick values just after a falling edge and samples one nanosecond later, within the same cycle. A code write is captured on the rising edge and is visible at the next falling edge. The bench also checks, before that edge, that the readback still shows the old code. Prescaler strobes are combinational on the tick and the stage counters. With the tick held high from the cycle after configuration, the bench counts every sample over exactly 20000 cycles and expects 20000/10^(k-1) pulses for code k.

// File: rtl/ctr_src_pkg.sv
package ctr_src_pkg;

    localparam int unsigned CH_PER_CHIP = 3;
    localparam int unsigned CODE_W      = 3;
    localparam int unsigned DIV_STAGES  = 4;

    typedef enum logic [CODE_W-1:0] {
        CK_PIN      = 3'd0,
        CK_F0       = 3'd1,
        CK_F1       = 3'd2,
        CK_F2       = 3'd3,
        CK_F3       = 3'd4,
        CK_F4       = 3'd5,
        CK_PREV_OUT = 3'd6,
        CK_CHIP_EXT = 3'd7
    } clk_sel_e;

    typedef enum logic [CODE_W-1:0] {
        GT_HIGH    = 3'd0,
        GT_LOW     = 3'd1,
        GT_PIN     = 3'd2,
        GT_NOT_OUT = 3'd3,
        GT_RSV4    = 3'd4,
        GT_RSV5    = 3'd5,
        GT_RSV6    = 3'd6,
        GT_RSV7    = 3'd7
    } gate_sel_e;

    typedef struct packed {
        clk_sel_e  clk;
        gate_sel_e gate;
    } chan_cfg_t;

    function automatic int unsigned idx_w(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int unsigned prior_chip(int unsigned chip, int unsigned n_chips);
        return (chip == 0) ? n_chips - 1 : chip - 1;
    endfunction

    function automatic int unsigned clk_link(int unsigned chip, int unsigned ch,
                                             int unsigned n_chips);
        if (ch > 0)
            return chip * CH_PER_CHIP + ch - 1;
        return prior_chip(chip, n_chips) * CH_PER_CHIP + 2;
    endfunction

    function automatic int unsigned gate_link(int unsigned chip, int unsigned ch,
                                              int unsigned n_chips);
        if (ch == 2)
            return chip * CH_PER_CHIP;
        return prior_chip(chip, n_chips) * CH_PER_CHIP + ch + 1;
    endfunction

endpackage

// File: rtl/ctr_src_prescale.sv
module ctr_src_prescale
    import ctr_src_pkg::*;
#(
    parameter int unsigned RATIO = 10
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  tick_i,
    output logic [DIV_STAGES:0]   stb_o
);
    localparam int unsigned CNT_W = $clog2(RATIO);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

    assign stb_o[0] = tick_i;

    for (genvar k = 1; k <= DIV_STAGES; k++) begin : g_stage
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk_i) begin
            if (rst_i)
                cnt_q <= '0;
            else if (stb_o[k-1])
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end

        assign stb_o[k] = stb_o[k-1] && (cnt_q == LAST);
    end
endmodule

// File: rtl/ctr_src_cfg.sv
module ctr_src_cfg
    import ctr_src_pkg::*;
#(
    parameter int unsigned NUM_CHIPS = 2,
    localparam int unsigned NCH      = NUM_CHIPS * CH_PER_CHIP,
    localparam int unsigned CW       = idx_w(NUM_CHIPS)
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     wr_en_i,
    input  logic                     wr_gate_i,
    input  logic [CW-1:0]            wr_chip_i,
    input  logic [1:0]               wr_chan_i,
    input  logic [CODE_W-1:0]        wr_code_i,
    input  logic                     rd_gate_i,
    input  logic [CW-1:0]            rd_chip_i,
    input  logic [1:0]               rd_chan_i,
    output logic [CODE_W-1:0]        rd_code_o,
    output chan_cfg_t [NCH-1:0]      cfg_o
);
    logic wr_ok;
    logic rd_ok;
    int unsigned wr_idx;
    int unsigned rd_idx;

    always_comb begin
        wr_ok  = (int'(wr_chip_i) < int'(NUM_CHIPS)) && (wr_chan_i != 2'd3);
        rd_ok  = (int'(rd_chip_i) < int'(NUM_CHIPS)) && (rd_chan_i != 2'd3);
        wr_idx = int'(wr_chip_i) * CH_PER_CHIP + int'(wr_chan_i);
        rd_idx = int'(rd_chip_i) * CH_PER_CHIP + int'(rd_chan_i);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic hit;
        assign hit = wr_en_i && wr_ok && (wr_idx == i);

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                cfg_o[i].clk  <= CK_PIN;
                cfg_o[i].gate <= GT_HIGH;
            end else if (hit) begin
                if (wr_gate_i)
                    cfg_o[i].gate <= gate_sel_e'(wr_code_i);
                else
                    cfg_o[i].clk  <= clk_sel_e'(wr_code_i);
            end
        end
    end

    always_comb begin
        rd_code_o = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_ok && rd_idx == i)
                rd_code_o = rd_gate_i ? cfg_o[i].gate : cfg_o[i].clk;
        end
    end
endmodule

// File: rtl/ctr_src_route.sv
module ctr_src_route
    import ctr_src_pkg::*;
#(
    parameter int unsigned NUM_CHIPS = 2,
    localparam int unsigned NCH      = NUM_CHIPS * CH_PER_CHIP
) (
    input  chan_cfg_t [NCH-1:0]     cfg_i,
    input  logic [DIV_STAGES:0]     stb_i,
    input  logic [NUM_CHIPS-1:0]    ext_clk_i,
    input  logic [NCH-1:0]          clk_pin_i,
    input  logic [NCH-1:0]          gat_pin_i,
    input  logic [NCH-1:0]          cnt_out_i,
    output logic [NCH-1:0]          cnt_clk_o,
    output logic [NCH-1:0]          cnt_gate_o,
    output logic [NCH-1:0]          clk_oe_o,
    output logic [NCH-1:0]          gat_oe_o
);
    for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
        for (genvar h = 0; h < CH_PER_CHIP; h++) begin : g_ch
            localparam int unsigned I  = c * CH_PER_CHIP + h;
            localparam int unsigned CL = clk_link(c, h, NUM_CHIPS);
            localparam int unsigned GL = gate_link(c, h, NUM_CHIPS);

            always_comb begin
                unique case (cfg_i[I].clk)
                    CK_PIN:      cnt_clk_o[I] = clk_pin_i[I];
                    CK_F0:       cnt_clk_o[I] = stb_i[0];
                    CK_F1:       cnt_clk_o[I] = stb_i[1];
                    CK_F2:       cnt_clk_o[I] = stb_i[2];
                    CK_F3:       cnt_clk_o[I] = stb_i[3];
                    CK_F4:       cnt_clk_o[I] = stb_i[4];
                    CK_PREV_OUT: cnt_clk_o[I] = cnt_out_i[CL];
                    CK_CHIP_EXT: cnt_clk_o[I] = ext_clk_i[c];
                    default:     cnt_clk_o[I] = 1'b0;
                endcase

                case (cfg_i[I].gate)
                    GT_HIGH:    cnt_gate_o[I] = 1'b1;
                    GT_LOW:     cnt_gate_o[I] = 1'b0;
                    GT_PIN:     cnt_gate_o[I] = gat_pin_i[I];
                    GT_NOT_OUT: cnt_gate_o[I] = ~cnt_out_i[GL];
                    default:    cnt_gate_o[I] = 1'b0;
                endcase

                clk_oe_o[I] = (cfg_i[I].clk  != CK_PIN);
                gat_oe_o[I] = (cfg_i[I].gate != GT_PIN);
            end
        end
    end
endmodule

// File: rtl/ctr_src_select.sv
module ctr_src_select
    import ctr_src_pkg::*;
#(
    parameter int unsigned NUM_CHIPS = 2,
    parameter int unsigned RATIO     = 10,
    localparam int unsigned NCH      = NUM_CHIPS * CH_PER_CHIP,
    localparam int unsigned CW       = idx_w(NUM_CHIPS)
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  tick_base_i,
    input  logic                  wr_en_i,
    input  logic                  wr_gate_i,
    input  logic [CW-1:0]         wr_chip_i,
    input  logic [1:0]            wr_chan_i,
    input  logic [CODE_W-1:0]     wr_code_i,
    input  logic                  rd_gate_i,
    input  logic [CW-1:0]         rd_chip_i,
    input  logic [1:0]            rd_chan_i,
    output logic [CODE_W-1:0]     rd_code_o,
    input  logic [NUM_CHIPS-1:0]  ext_clk_i,
    input  logic [NCH-1:0]        clk_pin_i,
    input  logic [NCH-1:0]        gat_pin_i,
    input  logic [NCH-1:0]        cnt_out_i,
    output logic [NCH-1:0]        cnt_clk_o,
    output logic [NCH-1:0]        cnt_gate_o,
    output logic [NCH-1:0]        clk_pin_o,
    output logic [NCH-1:0]        clk_pin_oe_o,
    output logic [NCH-1:0]        gat_pin_o,
    output logic [NCH-1:0]        gat_pin_oe_o
);
    chan_cfg_t [NCH-1:0]   cfg;
    logic [DIV_STAGES:0]   pre_stb;

    ctr_src_prescale #(.RATIO(RATIO)) i_prescale (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick_base_i),
        .stb_o  (pre_stb)
    );

    ctr_src_cfg #(.NUM_CHIPS(NUM_CHIPS)) i_cfg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_gate_i (wr_gate_i),
        .wr_chip_i (wr_chip_i),
        .wr_chan_i (wr_chan_i),
        .wr_code_i (wr_code_i),
        .rd_gate_i (rd_gate_i),
        .rd_chip_i (rd_chip_i),
        .rd_chan_i (rd_chan_i),
        .rd_code_o (rd_code_o),
        .cfg_o     (cfg)
    );

    ctr_src_route #(.NUM_CHIPS(NUM_CHIPS)) i_route (
        .cfg_i      (cfg),
        .stb_i      (pre_stb),
        .ext_clk_i  (ext_clk_i),
        .clk_pin_i  (clk_pin_i),
        .gat_pin_i  (gat_pin_i),
        .cnt_out_i  (cnt_out_i),
        .cnt_clk_o  (cnt_clk_o),
        .cnt_gate_o (cnt_gate_o),
        .clk_oe_o   (clk_pin_oe_o),
        .gat_oe_o   (gat_pin_oe_o)
    );

    assign clk_pin_o = cnt_clk_o;
    assign gat_pin_o = cnt_gate_o;
endmodule

// File: rtl/ctr_src_select_chk.sv
module ctr_src_select_chk
    import ctr_src_pkg::*;
#(
    parameter int unsigned NUM_CHIPS = 2,
    localparam int unsigned NCH      = NUM_CHIPS * CH_PER_CHIP,
    localparam int unsigned CW       = idx_w(NUM_CHIPS)
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 wr_en_i,
    input logic                 rd_gate_i,
    input logic [CW-1:0]        rd_chip_i,
    input logic [1:0]           rd_chan_i,
    input logic [CODE_W-1:0]    rd_code_o,
    input logic [NCH-1:0]       clk_pin_i,
    input logic [NCH-1:0]       gat_pin_i,
    input logic [NCH-1:0]       cnt_clk_o,
    input logic [NCH-1:0]       cnt_gate_o,
    input logic [NCH-1:0]       clk_pin_oe_o,
    input logic [NCH-1:0]       gat_pin_oe_o,
    input logic [DIV_STAGES:0]  pre_stb
);
    AST_RESET_PIN_DIR: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (clk_pin_oe_o == '0 && gat_pin_oe_o == '1 && cnt_gate_o == '1)); // R1

    AST_READ_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(wr_en_i) && $stable(rd_gate_i) && $stable(rd_chip_i) && $stable(rd_chan_i))
        |-> $stable(rd_code_o)); // R2

    for (genvar i = 0; i < NCH; i++) begin : g_pin
        AST_CLK_PIN_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
            !clk_pin_oe_o[i] |-> (cnt_clk_o[i] == clk_pin_i[i])); // R10

        AST_GAT_PIN_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
            !gat_pin_oe_o[i] |-> (cnt_gate_o[i] == gat_pin_i[i])); // R10
    end

    for (genvar k = 1; k <= DIV_STAGES; k++) begin : g_stb
        AST_STROBE_NESTED: assert property (@(posedge clk_i) disable iff (rst_i)
            pre_stb[k] |-> pre_stb[k-1]); // R5

        AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
            pre_stb[k] |=> !pre_stb[k]); // R5
    end
endmodule

bind ctr_src_select ctr_src_select_chk #(.NUM_CHIPS(NUM_CHIPS)) i_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .wr_en_i      (wr_en_i),
    .rd_gate_i    (rd_gate_i),
    .rd_chip_i    (rd_chip_i),
    .rd_chan_i    (rd_chan_i),
    .rd_code_o    (rd_code_o),
    .clk_pin_i    (clk_pin_i),
    .gat_pin_i    (gat_pin_i),
    .cnt_clk_o    (cnt_clk_o),
    .cnt_gate_o   (cnt_gate_o),
    .clk_pin_oe_o (clk_pin_oe_o),
    .gat_pin_oe_o (gat_pin_oe_o),
    .pre_stb      (pre_stb)
);

// File: tb/test_ctr_src_select.sv
module test_ctr_src_select;
    localparam int NC  = 2;
    localparam int NCH = NC * 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic wr_en = 1'b0, wr_gate = 1'b0;
    logic [0:0] wr_chip = '0, rd_chip = '0;
    logic [1:0] wr_chan = '0, rd_chan = '0;
    logic [2:0] wr_code = '0;
    logic rd_gate = 1'b0;
    logic [2:0] rd_code;
    logic [NC-1:0]  ext_clk = '0;
    logic [NCH-1:0] clk_pin = '0, gat_pin = '0, cnt_out = '0;
    logic [NCH-1:0] cnt_clk, cnt_gate, clk_pin_o, clk_oe, gat_pin_o, gat_oe;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    ctr_src_select #(.NUM_CHIPS(NC)) i_ctr_src_select (
        .clk_i(clk), .rst_i(rst), .tick_base_i(tick),
        .wr_en_i(wr_en), .wr_gate_i(wr_gate), .wr_chip_i(wr_chip),
        .wr_chan_i(wr_chan), .wr_code_i(wr_code),
        .rd_gate_i(rd_gate), .rd_chip_i(rd_chip), .rd_chan_i(rd_chan),
        .rd_code_o(rd_code), .ext_clk_i(ext_clk), .clk_pin_i(clk_pin),
        .gat_pin_i(gat_pin), .cnt_out_i(cnt_out), .cnt_clk_o(cnt_clk),
        .cnt_gate_o(cnt_gate), .clk_pin_o(clk_pin_o), .clk_pin_oe_o(clk_oe),
        .gat_pin_o(gat_pin_o), .gat_pin_oe_o(gat_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic wr_reg(input bit g, input int chip, input int ch, input int code);
        @(negedge clk);
        wr_en = 1'b1; wr_gate = g; wr_chip = 1'(chip); wr_chan = 2'(ch); wr_code = 3'(code);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input bit g, input int chip, input int ch);
        rd_gate = g; rd_chip = 1'(chip); rd_chan = 2'(ch);
        #1;
    endtask

    task automatic apply_pat(input int p);
        clk_pin = NCH'(p * 11 + 3);
        gat_pin = NCH'(p * 37 + 2);
        cnt_out = NCH'(p * 23 + 5);
        ext_clk = NC'(p * 3 + 1);
    endtask

    function automatic int prior(input int chip);
        return (chip == 0) ? NC - 1 : chip - 1;
    endfunction

    // Clock expectation from R4, R5 (tick held low), R6
    function automatic bit exp_clk(input int i, input int code);
        int chip = i / 3;
        int ch = i % 3;
        case (code)
            0: return clk_pin[i];
            1: return tick;
            6: return (ch > 0) ? cnt_out[i-1] : cnt_out[prior(chip)*3 + 2];
            7: return ext_clk[chip];
            default: return 1'b0;
        endcase
    endfunction

    // Gate expectation from R7, R8, R9
    function automatic bit exp_gate(input int i, input int code);
        int chip = i / 3;
        int ch = i % 3;
        case (code)
            0: return 1'b1;
            1: return 1'b0;
            2: return gat_pin[i];
            3: return (ch == 2) ? ~cnt_out[chip*3] : ~cnt_out[prior(chip)*3 + ch + 1];
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int cnt_pulse[5];
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(clk_oe == '0, "R1 clk oe", int'(clk_oe), 0);
        chk(gat_oe == '1, "R1 gat oe", int'(gat_oe), 63);
        chk(cnt_gate == '1, "R1 gate level", int'(cnt_gate), 63);
        for (int i = 0; i < NCH; i++) begin
            rd_reg(0, i / 3, i % 3);
            chk(rd_code == 3'd0, "R1 clk code", int'(rd_code), 0);
            rd_reg(1, i / 3, i % 3);
            chk(rd_code == 3'd0, "R1 gate code", int'(rd_code), 0);
        end

        // R11: code visible only after capturing edge
        @(negedge clk);
        rd_reg(0, 1, 1);
        wr_en = 1'b1; wr_gate = 1'b0; wr_chip = 1'b1; wr_chan = 2'd1; wr_code = 3'd6;
        #1;
        chk(rd_code == 3'd0, "R11 before edge", int'(rd_code), 0);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk(rd_code == 3'd6, "R11 after edge", int'(rd_code), 6);
        wr_reg(0, 1, 1, 0);

        // Clock sweep: R2, R4, R5, R6, R10
        for (int i = 0; i < NCH; i++) begin
            for (int c = 0; c < 8; c++) begin
                wr_reg(0, i / 3, i % 3, c);
                rd_reg(0, i / 3, i % 3);
                chk(rd_code == 3'(c), "R2 clk readback", int'(rd_code), c);
                for (int p = 0; p < 8; p++) begin
                    @(negedge clk);
                    apply_pat(p);
                    #1;
                    chk(cnt_clk[i] == exp_clk(i, c), "R4/R5/R6 clk route",
                        int'(cnt_clk[i]), int'(exp_clk(i, c)));
                    chk(clk_oe[i] == (c != 0), "R10 clk oe", int'(clk_oe[i]), int'(c != 0));
                    if (c != 0)
                        chk(clk_pin_o[i] == exp_clk(i, c), "R10 clk pin out",
                            int'(clk_pin_o[i]), int'(exp_clk(i, c)));
                end
            end
            wr_reg(0, i / 3, i % 3, 0);
        end

        // Gate sweep: R2, R7, R8, R9, R10
        for (int i = 0; i < NCH; i++) begin
            for (int c = 0; c < 8; c++) begin
                wr_reg(1, i / 3, i % 3, c);
                rd_reg(1, i / 3, i % 3);
                chk(rd_code == 3'(c), "R2 gate readback", int'(rd_code), c);
                for (int p = 0; p < 8; p++) begin
                    @(negedge clk);
                    apply_pat(p);
                    #1;
                    chk(cnt_gate[i] == exp_gate(i, c), "R7/R8/R9 gate route",
                        int'(cnt_gate[i]), int'(exp_gate(i, c)));
                    chk(gat_oe[i] == (c != 2), "R10 gat oe", int'(gat_oe[i]), int'(c != 2));
                    if (c != 2)
                        chk(gat_pin_o[i] == exp_gate(i, c), "R10 gat pin out",
                            int'(gat_pin_o[i]), int'(exp_gate(i, c)));
                end
            end
            wr_reg(1, i / 3, i % 3, 0);
        end

        // R3: channel index 3 writes are ignored
        wr_reg(0, 0, 3, 5);
        wr_reg(1, 1, 3, 5);
        for (int i = 0; i < NCH; i++) begin
            rd_reg(0, i / 3, i % 3);
            chk(rd_code == 3'd0, "R3 clk untouched", int'(rd_code), 0);
            rd_reg(1, i / 3, i % 3);
            chk(rd_code == 3'd0, "R3 gate untouched", int'(rd_code), 0);
        end
        rd_reg(0, 0, 3);
        chk(rd_code == 3'd0, "R3 invalid read", int'(rd_code), 0);
        chk(clk_oe == '0, "R3 clk oe unchanged", int'(clk_oe), 0);

        // R5: rates of the internal clocks (tick has been low since reset)
        for (int k = 0; k < 5; k++) wr_reg(0, k / 3, k % 3, k + 1);
        for (int k = 0; k < 5; k++) cnt_pulse[k] = 0;
        @(negedge clk);
        tick = 1'b1;
        for (int n = 0; n < 20000; n++) begin
            #1;
            for (int k = 0; k < 5; k++) if (cnt_clk[k]) cnt_pulse[k]++;
            @(negedge clk);
        end
        tick = 1'b0;
        chk(cnt_pulse[0] == 20000, "R5 base rate", cnt_pulse[0], 20000);
        chk(cnt_pulse[1] == 2000, "R5 div10", cnt_pulse[1], 2000);
        chk(cnt_pulse[2] == 200, "R5 div100", cnt_pulse[2], 200);
        chk(cnt_pulse[3] == 20, "R5 div1000", cnt_pulse[3], 20);
        chk(cnt_pulse[4] == 2, "R5 div10000", cnt_pulse[4], 2);

        summary();
        $finish;
    end
endmodule